// File: doc/BRIEF.md
# Memory Window Base Address Register

This block is a single memory-space base address register of the kind found in a device's configuration header. Configuration software reaches it through a small dword-wide read/write port: it can write a base address, read it back, and probe the window size. The window size is a power-of-two parameter. Address bits below that size are held at zero and ignore writes. A probe that writes all ones and reads the register back therefore sees the size as the position of the lowest set address bit, together with the fixed attribute bits.

The register can be built as a 32-bit or a 64-bit variant. In the 64-bit variant a second dword holds address bits 63..32. The block also compares incoming memory request addresses against the programmed base. It raises a hit when the address lies inside the window and memory decoding is enabled.

The size parameter must be a power of two of at least 16 bytes. A 32-bit variant also needs a window below 2 GB. Any other value stops elaboration with an error.

Top module: `mem_window_bar`

## Requirements
- R1: After reset every base bit is zero: dword 0 reads back only its attribute bits and dword 1 reads zero.
- R2: Dword 0 bits 3..0 are fixed and ignore writes. Bit 0 reads 0 (memory space). Bits 2:1 read 2'b00 for the 32-bit variant and 2'b10 for the 64-bit variant. Bit 3 reads the prefetchable parameter (1 = prefetchable).
- R3: After writing all ones to dword 0 with all byte enables set, dword 0 reads ((32'hFFFF_FFFF << log2(size)) | attribute bits) when log2(size) < 32, and reads only the attribute bits otherwise.
- R4: In the 64-bit variant, dword 1 (cfg_sel = 1) holds address bits 63..32. For windows of 4 GB or less it is fully writable. For larger windows its bits below (log2(size) - 32) read zero. In the 32-bit variant dword 1 reads zero and ignores writes.
- R5: On a write, byte lane i (cfg_be[i], data bits 8i+7..8i) updates only when its enable is set. A write with no enables leaves the register unchanged.
- R6: With mem_en high, req_hit is 1 exactly when req_addr[63:log2(size)] equals the programmed base bits. In the 32-bit variant this also requires req_addr[63:32] to be zero.
- R7: req_hit is 0 whenever mem_en is 0.
- R8: cfg_rdata combinationally reflects the dword chosen by cfg_sel. A write sampled at a rising clock edge is visible right after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | Dword select: 0 = low dword with attributes, 1 = upper address dword |
| cfg_be | input | 4 | Byte enables for the write |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data of the selected dword |
| mem_en | input | 1 | Memory-space decode enable |
| req_addr | input | 64 | Memory request address |
| req_hit | output | 1 | Request address falls inside the programmed window |

## Verification
The hardest case to reach from the ports is a window of 4 GB or more. There the size boundary falls inside the upper dword, and the lower dword keeps no writable bit at all. The bench instantiates three variants side by side on shared inputs: 1 MB 64-bit prefetchable, 4 KB 32-bit, and 8 GB 64-bit. A single write sequence then shows three different masks, and the same request address gives three different hit results. A partial byte-enable write that straddles the size boundary shows that lane gating and read-only masking are applied together.

// File: rtl/membar_pkg.sv
package membar_pkg;

  // exact log2 of a power of two (returns bit index of the single set bit)
  function automatic int unsigned win_log2(input logic [63:0] bytes);
    int unsigned r;
    r = 0;
    for (int i = 0; i < 64; i++) begin
      if (bytes[i]) r = i;
    end
    return r;
  endfunction

  function automatic bit win_legal(input logic [63:0] bytes, input bit wide);
    bit pow2;
    pow2 = (bytes != 64'd0) && ((bytes & (bytes - 64'd1)) == 64'd0);
    if (!pow2) return 1'b0;
    if (bytes < 64'd16) return 1'b0;
    if (!wide && (win_log2(bytes) > 30)) return 1'b0;
    return 1'b1;
  endfunction

  // which of the 64 address bits software may write
  function automatic logic [63:0] base_wmask(input logic [63:0] bytes, input bit wide);
    logic [63:0] m;
    m = ~(bytes - 64'd1);
    m[3:0] = 4'b0000;
    if (!wide) m[63:32] = 32'd0;
    return m;
  endfunction

  // fixed low nibble of dword 0
  function automatic logic [3:0] attr_nibble(input bit wide, input bit prefetch);
    return {prefetch, wide ? 2'b10 : 2'b00, 1'b0};
  endfunction

endpackage

// File: rtl/membar_dword.sv
module membar_dword #(
  parameter int unsigned W = 32,
  parameter logic [W-1:0] WMASK = '1,
  localparam int unsigned LANES = W / 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [LANES-1:0] be,
  input  logic [W-1:0]     wdata,
  output logic [W-1:0]     q
);

  logic [W-1:0] lane_mask;
  logic [W-1:0] upd_mask;

  genvar gi;
  generate
    for (gi = 0; gi < LANES; gi++) begin : g_lane
      assign lane_mask[gi*8 +: 8] = {8{be[gi]}};
    end
  endgenerate

  assign upd_mask = lane_mask & WMASK;

  always_ff @(posedge clk) begin
    if (!rst_n) q <= '0;
    else if (wr_en) q <= (q & ~upd_mask) | (wdata & upd_mask);
  end

  assert_idle_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(q));

  assert_ro_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ((q & ~WMASK) == '0));

  generate
    for (gi = 0; gi < LANES; gi++) begin : g_lane_chk
      assert_lane_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !be[gi]) |=> $stable(q[gi*8 +: 8]));
    end
  endgenerate

endmodule

// File: rtl/membar_match.sv
module membar_match #(
  parameter int unsigned AW = 64,
  parameter logic [AW-1:0] DMASK = '1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mem_en,
  input  logic [AW-1:0] addr,
  input  logic [AW-1:0] base,
  output logic          hit
);

  logic [AW-1:0] diff;
  logic          in_window;

  assign diff      = (addr ^ base) & DMASK;
  assign in_window = (diff == '0);
  assign hit       = mem_en && in_window;

  assert_hit_needs_en_R7: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> mem_en);

  assert_hit_window_R6: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> ((addr & DMASK) == (base & DMASK)));

endmodule

// File: rtl/mem_window_bar.sv
module mem_window_bar #(
  parameter logic [63:0] WIN_BYTES = 64'h0000_0000_0010_0000,
  parameter bit          IS_64    = 1'b1,
  parameter bit          PREFETCH = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_wr,
  input  logic        cfg_sel,
  input  logic [3:0]  cfg_be,
  input  logic [31:0] cfg_wdata,
  output logic [31:0] cfg_rdata,
  input  logic        mem_en,
  input  logic [63:0] req_addr,
  output logic        req_hit
);
  import membar_pkg::*;

  localparam logic [63:0] WMASK = base_wmask(WIN_BYTES, IS_64);
  localparam logic [3:0]  ATTR  = attr_nibble(IS_64, PREFETCH);
  localparam logic [63:0] DMASK = ~(WIN_BYTES - 64'd1);

  generate
    if (!win_legal(WIN_BYTES, IS_64)) begin : g_bad_size
      $error("mem_window_bar: window size must be a power of two >= 16 (and < 2 GB for 32-bit)");
    end
  endgenerate

  logic [31:0] dw_q [2];
  logic [63:0] base;
  logic        wr_lo, wr_hi;

  assign wr_lo = cfg_wr && (cfg_sel == 1'b0);
  assign wr_hi = cfg_wr && (cfg_sel == 1'b1);

  membar_dword #(.W(32), .WMASK(WMASK[31:0])) u_lo (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_lo), .be(cfg_be),
    .wdata(cfg_wdata), .q(dw_q[0]));

  membar_dword #(.W(32), .WMASK(WMASK[63:32])) u_hi (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_hi), .be(cfg_be),
    .wdata(cfg_wdata), .q(dw_q[1]));

  assign base = {dw_q[1], dw_q[0]};

  assign cfg_rdata = cfg_sel ? dw_q[1] : (dw_q[0] | {28'd0, ATTR});

  membar_match #(.AW(64), .DMASK(DMASK)) u_match (
    .clk(clk), .rst_n(rst_n), .mem_en(mem_en), .addr(req_addr),
    .base(base), .hit(req_hit));

  assert_attr_fixed_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_sel |-> (cfg_rdata[3:0] == ATTR));

  generate
    if (!IS_64) begin : g_narrow_chk
      assert_hi_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_sel |-> (cfg_rdata == 32'd0));
    end
  endgenerate

endmodule

// File: tb/sim_mem_window_bar.sv
module sim_mem_window_bar;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic        cfg_sel = 1'b0;
  logic [3:0]  cfg_be = 4'h0;
  logic [31:0] cfg_wdata = 32'd0;
  logic        mem_en = 1'b0;
  logic [63:0] req_addr = 64'd0;
  logic [31:0] rd0, rd1, rd2;
  logic        hit0, hit1, hit2;

  int checks = 0;
  int fails = 0;
  bit reported = 1'b0;

  always #4 clk = ~clk;

  // 1 MB, 64-bit, prefetchable
  mem_window_bar u0 (.clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
    .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .cfg_rdata(rd0), .mem_en(mem_en),
    .req_addr(req_addr), .req_hit(hit0));
  // 4 KB, 32-bit, not prefetchable
  mem_window_bar #(.WIN_BYTES(64'h1000), .IS_64(1'b0), .PREFETCH(1'b0)) u1 (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
    .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .cfg_rdata(rd1), .mem_en(mem_en),
    .req_addr(req_addr), .req_hit(hit1));
  // 8 GB, 64-bit, not prefetchable
  mem_window_bar #(.WIN_BYTES(64'h2_0000_0000), .IS_64(1'b1), .PREFETCH(1'b0)) u2 (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
    .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .cfg_rdata(rd2), .mem_en(mem_en),
    .req_addr(req_addr), .req_hit(hit2));

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic do_write(input logic sel, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_sel = sel; cfg_be = be; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0; cfg_be = 4'h0;
  endtask

  task automatic read_all(input logic sel);
    @(negedge clk);
    cfg_sel = sel;
    #1;
  endtask

  task automatic probe(input logic en, input logic [63:0] a);
    @(negedge clk);
    mem_en = en; req_addr = a;
    #1;
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    read_all(1'b0);
    chk("R1 u0 lo", rd0, 32'h0000_000C);
    chk("R1 u1 lo", rd1, 32'h0000_0000);
    chk("R1 u2 lo", rd2, 32'h0000_0004);
    read_all(1'b1);
    chk("R1 u0 hi", rd0, 32'd0);
    chk("R1 u2 hi", rd2, 32'd0);
  endtask

  task automatic t_attr_readonly;
    do_write(1'b0, 4'hF, 32'h0000_000F);
    read_all(1'b0);
    chk("R2 u0 attr", rd0, 32'h0000_000C);
    chk("R2 u1 attr", rd1, 32'h0000_0000);
    chk("R2 u2 attr", rd2, 32'h0000_0004);
  endtask

  task automatic t_byte_enable;
    do_write(1'b0, 4'b0100, 32'hFFFF_FFFF);
    read_all(1'b0);
    chk("R5 u0 lane2", rd0, 32'h00F0_000C);
    chk("R5 u1 lane2", rd1, 32'h00FF_0000);
    chk("R5 u2 lane2", rd2, 32'h0000_0004);
    do_write(1'b0, 4'b0000, 32'h0000_0000);
    read_all(1'b0);
    chk("R5 u0 no-be", rd0, 32'h00F0_000C);
    chk("R5 u1 no-be", rd1, 32'h00FF_0000);
  endtask

  task automatic t_sizing;
    do_write(1'b0, 4'hF, 32'hFFFF_FFFF);
    read_all(1'b0);
    chk("R3 u0 size 1MB", rd0, 32'hFFF0_000C);
    chk("R3 u1 size 4KB", rd1, 32'hFFFF_F000);
    chk("R3 u2 size 8GB", rd2, 32'h0000_0004);
  endtask

  task automatic t_upper;
    do_write(1'b1, 4'hF, 32'hFFFF_FFFF);
    read_all(1'b1);
    chk("R4 u0 hi all", rd0, 32'hFFFF_FFFF);
    chk("R4 u1 hi narrow", rd1, 32'h0000_0000);
    chk("R4 u2 hi masked", rd2, 32'hFFFF_FFFE);
  endtask

  task automatic t_decode;
    do_write(1'b0, 4'hF, 32'h1230_0000);
    do_write(1'b1, 4'hF, 32'h0000_0005);
    read_all(1'b0);
    chk("R8 u0 lo base", rd0, 32'h1230_000C);
    read_all(1'b1);
    chk("R8 u2 hi base", rd2, 32'h0000_0004);
    probe(1'b1, 64'h5_1230_0000);
    chk("R6 u0 low edge", {31'd0, hit0}, 32'd1);
    chk("R6 u1 upper nonzero", {31'd0, hit1}, 32'd0);
    chk("R6 u2 big window", {31'd0, hit2}, 32'd1);
    probe(1'b1, 64'h5_123F_FFFF);
    chk("R6 u0 top edge", {31'd0, hit0}, 32'd1);
    probe(1'b1, 64'h5_1240_0000);
    chk("R6 u0 past end", {31'd0, hit0}, 32'd0);
    probe(1'b1, 64'h4_1230_0000);
    chk("R6 u0 wrong upper", {31'd0, hit0}, 32'd0);
    chk("R6 u2 lower half", {31'd0, hit2}, 32'd1);
    probe(1'b1, 64'h6_0000_0000);
    chk("R6 u2 outside", {31'd0, hit2}, 32'd0);
    probe(1'b1, 64'h0_1230_0FFF);
    chk("R6 u1 in 4KB", {31'd0, hit1}, 32'd1);
    probe(1'b1, 64'h0_1230_1000);
    chk("R6 u1 past 4KB", {31'd0, hit1}, 32'd0);
    probe(1'b0, 64'h5_1230_0000);
    chk("R7 u0 disabled", {31'd0, hit0}, 32'd0);
    chk("R7 u2 disabled", {31'd0, hit2}, 32'd0);
    probe(1'b0, 64'h0_1230_0000);
    chk("R7 u1 disabled", {31'd0, hit1}, 32'd0);
  endtask

  task automatic summary;
    if (!reported) begin
      reported = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    t_reset();
    t_attr_readonly();
    t_byte_enable();
    t_sizing();
    t_upper();
    t_decode();
    t_reset();
    summary();
  end
endmodule